// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block runs single conversions on an external 16-bit analog-to-digital converter that sits behind a ten-way input multiplexer. Inputs 0 to 7 are signal channels, input 8 is the +10 V reference and input 9 is the 0 V reference. Software drives the block through four 16-bit registers on a simple synchronous write bus with a combinational read path.

The registers are a conversion control word, a sample word, an interrupt enable word and a status word whose done flag is cleared by writing one. A single control word holds the selector of the input to convert, a ten-bit enable mask with one bit per input, a flag that asks for a settling pause, and a go bit. The pause is a fixed number of clock cycles placed between the multiplexer switching and the start strobe to the converter.

A state machine with four states does the sequencing:
- `ST_IDLE` waits for a go request.
- `ST_SETTLE` counts out the settling pause.
- `ST_STROBE` pulses the converter start for one cycle.
- `ST_WAIT` holds until the converter reports done.

It moves through these transitions:
- `ST_IDLE` to `ST_SETTLE` on go with the settle flag set.
- `ST_IDLE` to `ST_STROBE` on go without the settle flag.
- `ST_SETTLE` to `ST_STROBE` when the pause count is spent.
- `ST_STROBE` to `ST_WAIT` always.
- `ST_WAIT` to `ST_IDLE` on done, when the sample is captured and the done flag is raised.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, every register reads 0x0000, and `irq`, `adc_start` and `mux_sel` are 0.
- R2: A write to offset 0x06 with bit 0 set, made while the block is idle, starts one conversion. From the next cycle `mux_sel` equals bits 4:1 of the written word. If bit 15 is clear, `adc_start` is high for exactly one cycle, namely the first cycle after the write edge.
- R3: If bit 15 of that control word is set, the one-cycle `adc_start` pulse comes `SETTLE_CYCLES` cycles later than it would with bit 15 clear.
- R4: Any write to the control offset while a conversion is in progress is ignored. No extra start pulse is issued, `mux_sel` does not change, and the stored control bits do not change.
- R5: When `adc_done` is seen while waiting, the sample register at offset 0x08 takes `adc_data` XOR 0x8000, provided the selected input index is 0 to 9 and its enable bit (bit 5 plus index of the control word) is set.
- R6: A conversion on an input whose enable bit is clear, or on an index of 10 to 15, still completes, but it stores 0x0000.
- R7: Bit 2 of the status register at offset 0x0E is set on each capture. Writing a word with bit 2 set clears it, and writing 0 leaves it unchanged. If a capture and a clear fall in the same cycle, the flag ends up set.
- R8: The interrupt enable register at offset 0x0C keeps only bit 2 (all other bits read 0). `irq` is high exactly when status bit 2 and enable bit 2 are both 1.
- R9: Reading the control offset returns the stored bits 15:1 of the last accepted control word, with bit 0 reading 1 while a conversion is in progress. A control write with bit 0 clear stores the word without starting a conversion.
- R10: Writes to the sample offset have no effect, and reads of any unmapped offset return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| mux_sel | output | 4 | Input multiplexer selector |
| adc_start | output | 1 | One-cycle conversion start strobe |
| adc_done | input | 1 | Converter done pulse, with `adc_data` valid |
| adc_data | input | 16 | Converter output code |
| irq | output | 1 | Done interrupt |

## Verification
The capture of a sample and a software write-one-to-clear of the done flag can land on the same clock edge. The bench provokes this by turning off its automatic converter model, waiting until the machine is in its wait state, and then raising `adc_done` in the same cycle as a status write of 0x0004. It judges the outcome by reading the flag back as set and the new sample as present, then clearing the flag alone and reading 0. A near-exhaustive sweep covers all sixteen selector values, with and without the settling pause, under a full mask and under a mask missing only the selected input, and computes the expected sample and strobe timing arithmetically.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int unsigned WORD_W     = 16;
    localparam int unsigned ADDR_W     = 6;
    localparam int unsigned NUM_INPUTS = 10;
    localparam int unsigned SEL_W      = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h06;
    localparam logic [ADDR_W-1:0] OFF_DATA = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_IEN  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_IST  = 6'h0E;

    localparam int unsigned GO_BIT     = 0;
    localparam int unsigned SEL_LSB    = 1;
    localparam int unsigned MASK_LSB   = 5;
    localparam int unsigned SETTLE_BIT = 15;
    localparam int unsigned DONE_BIT   = 2;

    localparam logic [WORD_W-1:0] SIGN_FLIP = 16'h8000;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_STROBE = 2'd2,
        ST_WAIT   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic              cap_valid,
    input  logic [WORD_W-1:0] cap_data,
    output logic              start_req,
    output logic              settle_req,
    output logic [WORD_W-1:1] ctrl_q,
    output logic              ist_done,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    logic              ctrl_wr;
    logic              ist_clr;
    logic              ien_q;
    logic [WORD_W-1:0] data_q;

    // control writes are accepted only while idle
    assign ctrl_wr    = bus_we && (bus_addr == OFF_CTRL) && !busy;
    assign start_req  = ctrl_wr && bus_wdata[GO_BIT];
    assign settle_req = bus_wdata[SETTLE_BIT];
    assign ist_clr    = bus_we && (bus_addr == OFF_IST) && bus_wdata[DONE_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            ien_q    <= 1'b0;
            ist_done <= 1'b0;
            data_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= bus_wdata[WORD_W-1:1];
            end
            if (bus_we && (bus_addr == OFF_IEN)) begin
                ien_q <= bus_wdata[DONE_BIT];
            end
            // a capture in the same cycle as a clear wins
            if (cap_valid) begin
                ist_done <= 1'b1;
            end else if (ist_clr) begin
                ist_done <= 1'b0;
            end
            if (cap_valid) begin
                data_q <= cap_data;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: bus_rdata = {ctrl_q, busy};
            OFF_DATA: bus_rdata = data_q;
            OFF_IEN:  bus_rdata[DONE_BIT] = ien_q;
            OFF_IST:  bus_rdata[DONE_BIT] = ist_done;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = ist_done & ien_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       settle_req,
    input  logic       adc_done,
    output seq_state_t state_q,
    output logic       busy,
    output logic       adc_start,
    output logic       cap_valid
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

    seq_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // settling counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_IDLE && start_req && settle_req) begin
            cnt_q <= CNT_LOAD;
        end else if (state_q == ST_SETTLE && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = settle_req ? ST_SETTLE : ST_STROBE;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) begin
                    state_d = ST_STROBE;
                end
            end
            ST_STROBE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (adc_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        adc_start = 1'b0;
        cap_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_SETTLE: busy = 1'b1;
            ST_STROBE: adc_start = 1'b1;
            ST_WAIT:   cap_valid = adc_done;
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture
    import adc_seq_pkg::*;
(
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM_INPUTS-1:0] enable_mask,
    input  logic [WORD_W-1:0]     adc_data,
    output logic [WORD_W-1:0]     cap_data
);
    localparam int unsigned SEL_SPAN = 2 ** SEL_W;

    logic [SEL_SPAN-1:0] en_vec;

    for (genvar g = 0; g < SEL_SPAN; g++) begin : g_en
        if (g < NUM_INPUTS) begin : g_real
            assign en_vec[g] = enable_mask[g];
        end else begin : g_none
            assign en_vec[g] = 1'b0;
        end
    end

    assign cap_data = en_vec[sel] ? (adc_data ^ SIGN_FLIP) : '0;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [SEL_W-1:0]  mux_sel,
    output logic              adc_start,
    input  logic              adc_done,
    input  logic [WORD_W-1:0] adc_data,
    output logic              irq
);
    seq_state_t        state_q;
    logic              busy;
    logic              cap_valid;
    logic              start_req;
    logic              settle_req;
    logic [WORD_W-1:1] ctrl_q;
    logic              ist_done;
    logic              wait_st;
    logic [WORD_W-1:0] cap_data;

    adc_seq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .busy       (busy),
        .cap_valid  (cap_valid),
        .cap_data   (cap_data),
        .start_req  (start_req),
        .settle_req (settle_req),
        .ctrl_q     (ctrl_q),
        .ist_done   (ist_done),
        .bus_rdata  (bus_rdata),
        .irq        (irq)
    );

    adc_seq_fsm #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .settle_req (settle_req),
        .adc_done   (adc_done),
        .state_q    (state_q),
        .busy       (busy),
        .adc_start  (adc_start),
        .cap_valid  (cap_valid)
    );

    adc_seq_capture u_cap (
        .sel         (ctrl_q[SEL_LSB+SEL_W-1:SEL_LSB]),
        .enable_mask (ctrl_q[MASK_LSB+NUM_INPUTS-1:MASK_LSB]),
        .adc_data    (adc_data),
        .cap_data    (cap_data)
    );

    assign mux_sel = ctrl_q[SEL_LSB+SEL_W-1:SEL_LSB];
    assign wait_st = (state_q == ST_WAIT);
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              adc_start,
    input logic              adc_done,
    input logic [SEL_W-1:0]  mux_sel,
    input logic              irq,
    input logic              busy,
    input logic              ist_done,
    input logic              wait_st
);
    // R2: start strobe lasts a single cycle
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R4: selector frozen while a conversion is in progress
    a_r4_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_sel));

    // R7: a capture raises the done flag
    a_r7_set_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_st && adc_done) |=> ist_done);

    // R7: write-one clears the flag when no capture coincides
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_IST && bus_wdata[DONE_BIT] && !(wait_st && adc_done))
        |=> !ist_done);

    // R8: clearing the enable silences the interrupt
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_IEN && !bus_wdata[DONE_BIT]) |=> !irq);
endmodule

bind adc_seq_top adc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .adc_start (adc_start),
    .adc_done  (adc_done),
    .mux_sel   (mux_sel),
    .irq       (irq),
    .busy      (busy),
    .ist_done  (ist_done),
    .wait_st   (wait_st)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  mux_sel;
    logic        adc_start;
    logic        adc_done = 1'b0;
    logic [15:0] adc_data = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int strobe_cnt = 0;
    int last_strobe_cyc = 0;
    int pend = 0;
    int lat = 3;
    bit auto_resp = 1'b1;
    logic [15:0] salt = 16'h2C41;

    adc_seq_top #(.SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mux_sel(mux_sel),
        .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] model_code(logic [15:0] s, logic [3:0] idx);
        return s ^ (16'(idx) * 16'h01B3);
    endfunction

    // converter model and strobe monitor
    always @(negedge clk) begin
        if (adc_start) begin
            strobe_cnt++;
            last_strobe_cyc = cyc;
        end
        if (auto_resp) begin
            adc_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    adc_done = 1'b1;
                    adc_data = model_code(salt, mux_sel);
                end
            end
            if (adc_start) pend = lat;
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] r;
        for (int i = 0; i < 200; i++) begin
            bus_read(6'h06, r);
            if (r[0] == 1'b0) break;
        end
    endtask

    task automatic conv(logic [3:0] idx, logic [9:0] mask, bit dly);
        int s0, cw;
        logic [15:0] r, exp;
        s0 = strobe_cnt;
        bus_write(6'h06, {dly, mask, idx, 1'b1});
        cw = cyc;
        chk("R2 mux_sel", 16'(mux_sel), 16'(idx));
        wait_idle();
        chk("R2 one strobe", 16'(strobe_cnt - s0), 16'd1);
        chk(dly ? "R3 settle delay" : "R2 strobe timing",
            16'(last_strobe_cyc - cw), dly ? 16'(SETTLE) : 16'd0);
        exp = (idx < 10 && mask[idx]) ? (model_code(salt, idx) ^ 16'h8000) : 16'h0000;
        bus_read(6'h08, r);
        chk((idx < 10 && mask[idx]) ? "R5 sample" : "R6 zero sample", r, exp);
        bus_read(6'h0E, r);
        chk("R7 done set", r, 16'h0004);
        bus_write(6'h0E, 16'h0004);
        bus_read(6'h0E, r);
        chk("R7 done cleared", r, 16'h0000);
    endtask

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(6'h06, r); chk("R1 ctrl", r, 16'h0000);
        bus_read(6'h08, r); chk("R1 data", r, 16'h0000);
        bus_read(6'h0C, r); chk("R1 ien", r, 16'h0000);
        bus_read(6'h0E, r); chk("R1 ist", r, 16'h0000);
        chk("R1 irq", 16'(irq), 16'd0);
        chk("R1 start", 16'(adc_start), 16'd0);
        chk("R1 mux", 16'(mux_sel), 16'd0);

        // R10 unmapped and data write
        bus_read(6'h00, r); chk("R10 unmapped", r, 16'h0000);
        bus_write(6'h08, 16'h5A5A);
        bus_read(6'h08, r); chk("R10 data write ignored", r, 16'h0000);

        // R9 store without start
        bus_write(6'h06, 16'hABCE);
        repeat (3) @(negedge clk);
        chk("R9 no strobe", 16'(strobe_cnt), 16'd0);
        bus_read(6'h06, r); chk("R9 readback", r, 16'hABCE);

        // R8 interrupt enable
        bus_write(6'h0C, 16'hFFFF);
        bus_read(6'h0C, r); chk("R8 ien bits", r, 16'h0004);

        // sweep: every selector, with/without settle, full mask / own bit missing
        for (int idx = 0; idx < 16; idx++) begin
            for (int d = 0; d < 2; d++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [9:0] m;
                    m = (p == 1) ? (10'h3FF ^ (10'd1 << idx)) : 10'h3FF;
                    salt = 16'(idx * 16'h0F1D + d * 16'h3300 + p * 16'h0081);
                    conv(4'(idx), m, d[0]);
                end
            end
        end

        // R8 irq follows status AND enable
        lat = 3; salt = 16'h7777;
        bus_write(6'h06, {1'b0, 10'h3FF, 4'd2, 1'b1});
        wait_idle();
        chk("R8 irq both set", 16'(irq), 16'd1);
        bus_write(6'h0C, 16'h0000);
        chk("R8 irq masked", 16'(irq), 16'd0);
        bus_write(6'h0C, 16'h0004);
        chk("R8 irq reenabled", 16'(irq), 16'd1);
        bus_write(6'h0E, 16'h0000);
        bus_read(6'h0E, r); chk("R7 zero write keeps flag", r, 16'h0004);
        bus_write(6'h0E, 16'h0004);
        chk("R8 irq after clear", 16'(irq), 16'd0);

        // R4 start during busy ignored
        begin
            int s0;
            lat = 20; salt = 16'h1111;
            s0 = strobe_cnt;
            bus_write(6'h06, {1'b0, 10'h3FF, 4'd3, 1'b1});
            repeat (4) @(negedge clk);
            bus_read(6'h06, r); chk("R9 busy bit", 16'(r[0]), 16'd1);
            bus_write(6'h06, {1'b1, 10'h001, 4'd7, 1'b1});
            chk("R4 mux unchanged", 16'(mux_sel), 16'd3);
            wait_idle();
            repeat (25) @(negedge clk);
            chk("R4 single strobe", 16'(strobe_cnt - s0), 16'd1);
            chk("R4 mux after", 16'(mux_sel), 16'd3);
            bus_read(6'h06, r); chk("R4 ctrl kept", r, {1'b0, 10'h3FF, 4'd3, 1'b0});
            bus_read(6'h08, r); chk("R5 sample idx3", r, model_code(16'h1111, 4'd3) ^ 16'h8000);
            bus_write(6'h0E, 16'h0004);
        end

        // R7 capture and clear in the same cycle
        auto_resp = 1'b0;
        @(negedge clk); adc_done = 1'b0;
        bus_write(6'h06, {1'b0, 10'h3FF, 4'd1, 1'b1});
        repeat (3) @(negedge clk);
        bus_we = 1'b1; bus_addr = 6'h0E; bus_wdata = 16'h0004;
        adc_done = 1'b1; adc_data = 16'h0ACE;
        @(negedge clk);
        bus_we = 1'b0; adc_done = 1'b0;
        bus_read(6'h0E, r); chk("R7 set wins over clear", r, 16'h0004);
        bus_read(6'h08, r); chk("R5 race sample", r, 16'h8ACE);
        bus_read(6'h06, r); chk("R2 idle after race", 16'(r[0]), 16'd0);
        bus_write(6'h0E, 16'h0004);
        bus_read(6'h0E, r); chk("R7 clear alone", r, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule